// File: doc/BRIEF.md
# SIMD Processing Element with One-Row Memory Buffer

This block is a single processing element of a data-parallel array. Four controllers broadcast instruction streams to every element at once; each element follows exactly one of them, chosen by a 2-bit code in its own flag register. An activity bit in the same register decides whether broadcast instructions touch the element's state. Dedicated instructions set or clear that bit from a compare, so that data-dependent branches become per-element masking.

The element holds a 16 x 32-bit register file with two ports and an integer ALU. Its local memory slice sits behind a buffer that holds one complete memory row. An access to the buffered row completes in one cycle. An access to another row first spends a fixed number of cycles refilling the buffer. A missing load does not block the element: independent instructions keep flowing, and only hazardous ones are held back by a stall output. Register 15 doubles as the communication register, reachable from the second port.

Top module: `simd_pe`

## Requirements
- R1: After reset the flag byte reads 0x01 (active, following controller 0), busy, stall and wb_valid are 0, all registers read 0, and the row buffer is invalid, so the first memory access misses.
- R2: Only the instruction from the controller named by flag bits 2:1 is executed; the valid and instruction inputs of the other three have no effect. Opcode 14 (set-controller) loads the code from imm[1:0].
- R3: Flag bit 0 is the activity bit. When it is 0, every opcode except 13 (activate-all) has no effect and never stalls. Opcode 11 sets activity to (rs1 - rs2 == 0); opcode 12 sets it to the sign bit of rs1 - rs2; opcode 13 sets it to 1.
- R4: Instruction word: op [31:28], rd [27:24], rs1 [23:20], rs2 [19:16], imm [15:0]. Opcodes 1..8 are ADD, SUB, AND, OR, XOR, SHL, SHR (logical, amount rs2[4:0]) and ADDI (rs1 + sign-extended imm). The result is written to rd, and it is shown on wb_valid/wb_rd/wb_data in the cycle after acceptance.
- R5: Opcode 9 loads rd from, and opcode 10 stores rd to, word address rs1 + sext(imm). The word within the row is bits 2:0, and the row is bits 6:3. When the row equals the buffered row, the access completes in one cycle with no busy. Memory starts out holding 0x1000_0000 plus the word address.
- R6: A miss raises busy for exactly MISS_CYCLES (default 4) cycles. It then installs the row in the buffer and completes the access; a load shows its value on the write-back outputs in the first cycle with busy low.
- R7: A store updates both the buffer and memory, on a hit and on a miss, so a later load of that address returns the stored value.
- R8: While a miss is pending, the element stalls (stall high, instruction not taken) on any memory opcode, on any instruction that reads or writes the pending load's destination, and on any instruction in the last busy cycle. Other instructions proceed.
- R9: comm_rdata shows register 15. comm_we writes comm_wdata into register 15; if an instruction writes register 15 on the same edge, the instruction's value wins.
- R10: Flag bits 7:3 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_valid | input | 4 | Per-controller instruction valid |
| ctrl_instr | input | 4x32 | Per-controller broadcast instruction |
| stall | output | 1 | Selected instruction is held back this cycle |
| busy | output | 1 | Row refill in progress |
| pe_flags | output | 8 | Flag byte: bit 0 activity, bits 2:1 controller code |
| wb_valid | output | 1 | A register was written at the last edge |
| wb_rd | output | 4 | Register written |
| wb_data | output | 32 | Value written |
| comm_we | input | 1 | Communication write to register 15 |
| comm_wdata | input | 32 | Communication write data |
| comm_rdata | output | 32 | Current value of register 15 |

## Verification
Two things can compete in a single cycle. One is a refill finishing and writing its load result through the instruction port. The other is a new instruction that wants that same port, or that depends on the loaded register. The bench starts a miss and then offers an independent instruction, a dependent one, a store, and an instruction timed for the last busy cycle. It checks that each of them is either taken at once or held with stall high until busy falls, and that the load's value and the later result each appear on the write-back outputs in the expected cycle. A communication write and an instruction write to register 15 on the same edge are also set up together, and only the instruction's value is expected to remain.

// File: rtl/simd_pe_pkg.sv
// Shared types for the processing element: opcode set and instruction layout.
// Assumes a fixed 32-bit instruction word with 4-bit register fields.
package simd_pe_pkg;

    localparam int REG_AW = 4;
    localparam int NREG   = 1 << REG_AW;
    localparam int COMM_REG = NREG - 1;

    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_ADD    = 4'd1,
        OP_SUB    = 4'd2,
        OP_AND    = 4'd3,
        OP_OR     = 4'd4,
        OP_XOR    = 4'd5,
        OP_SHL    = 4'd6,
        OP_SHR    = 4'd7,
        OP_ADDI   = 4'd8,
        OP_LD     = 4'd9,
        OP_ST     = 4'd10,
        OP_ACTZ   = 4'd11,
        OP_ACTN   = 4'd12,
        OP_ACTALL = 4'd13,
        OP_SETCTL = 4'd14,
        OP_RSV    = 4'd15
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [REG_AW-1:0] rd;
        logic [REG_AW-1:0] rs1;
        logic [REG_AW-1:0] rs2;
        logic [15:0]       imm;
    } instr_t;

endpackage

// File: rtl/simd_pe_regfile.sv
// Two-port register file. Port A: three read taps and one write for
// instruction traffic. Port B: read/write of the fixed communication register.
// Assumes port A wins when both write the communication register on one edge.
module simd_pe_regfile #(
    parameter int DATA_W   = 32,
    parameter int NREG     = 16,
    parameter int COMM_IDX = 15,
    localparam int AW      = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     a_ra1,
    input  logic [AW-1:0]     a_ra2,
    input  logic [AW-1:0]     a_ra3,
    output logic [DATA_W-1:0] a_rd1,
    output logic [DATA_W-1:0] a_rd2,
    output logic [DATA_W-1:0] a_rd3,
    input  logic              a_we,
    input  logic [AW-1:0]     a_wa,
    input  logic [DATA_W-1:0] a_wd,
    input  logic              b_we,
    input  logic [DATA_W-1:0] b_wd,
    output logic [DATA_W-1:0] b_rd
);

    logic [DATA_W-1:0] regs [NREG];

    // Port A reads.
    always_comb begin
        a_rd1 = regs[a_ra1];
        a_rd2 = regs[a_ra2];
        a_rd3 = regs[a_ra3];
    end

    // Port B read of the communication register.
    assign b_rd = regs[COMM_IDX];

    // Register update; the later port A assignment takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else begin
            if (b_we) regs[COMM_IDX] <= b_wd;
            if (a_we) regs[a_wa] <= a_wd;
        end
    end

endmodule

// File: rtl/simd_pe_alu.sv
// Integer ALU: arithmetic, logic, shifts, and a subtract-based compare that
// feeds the activity instructions. Purely combinational.
module simd_pe_alu
    import simd_pe_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [15:0]       imm,
    output logic [DATA_W-1:0] result,
    output logic              zero,
    output logic              neg
);

    logic [DATA_W-1:0] diff;
    logic [DATA_W-1:0] simm;

    // Compare path and immediate sign extension.
    always_comb begin
        diff = a - b;
        zero = (diff == '0);
        neg  = diff[DATA_W-1];
        simm = {{(DATA_W-16){imm[15]}}, imm};
    end

    // Result select by opcode.
    always_comb begin
        unique case (op)
            OP_ADD:  result = a + b;
            OP_SUB:  result = diff;
            OP_AND:  result = a & b;
            OP_OR:   result = a | b;
            OP_XOR:  result = a ^ b;
            OP_SHL:  result = a << b[SH_W-1:0];
            OP_SHR:  result = a >> b[SH_W-1:0];
            OP_ADDI: result = a + simm;
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/simd_pe_rowbuf.sv
// Local memory slice behind a one-row buffer. A hit reads or writes the
// buffer in the same cycle (stores write through to memory). A miss latches
// the request, counts MISS_CYCLES with busy high, then installs the row and
// completes the access on the final edge. Assumes acc_en is only raised
// while busy is low, and ROW_WORDS and MEM_ROWS are powers of two.
module simd_pe_rowbuf #(
    parameter int DATA_W      = 32,
    parameter int ROW_WORDS   = 8,
    parameter int MEM_ROWS    = 16,
    parameter int MISS_CYCLES = 4,
    localparam int WORD_AW    = $clog2(ROW_WORDS),
    localparam int ROW_AW     = $clog2(MEM_ROWS),
    localparam int DEPTH      = ROW_WORDS * MEM_ROWS,
    localparam int CNT_W      = $clog2(MISS_CYCLES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_en,
    input  logic               acc_we,
    input  logic [ROW_AW-1:0]  acc_row,
    input  logic [WORD_AW-1:0] acc_word,
    input  logic [DATA_W-1:0]  acc_wdata,
    output logic               hit,
    output logic [DATA_W-1:0]  hit_rdata,
    output logic               busy,
    output logic               fin,
    output logic [DATA_W-1:0]  fin_rdata
);

    logic [DATA_W-1:0]  mem  [DEPTH];
    logic [DATA_W-1:0]  rbuf [ROW_WORDS];
    logic [ROW_AW-1:0]  tag_q;
    logic               tvalid_q;
    logic               busy_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               p_we_q;
    logic [ROW_AW-1:0]  p_row_q;
    logic [WORD_AW-1:0] p_word_q;
    logic [DATA_W-1:0]  p_wdata_q;
    logic               st_hit;
    logic               start_miss;

    // Lookup, completion and request classification.
    always_comb begin
        hit        = tvalid_q && (tag_q == acc_row);
        hit_rdata  = rbuf[acc_word];
        busy       = busy_q;
        fin        = busy_q && (cnt_q == '0);
        fin_rdata  = mem[{p_row_q, p_word_q}];
        st_hit     = acc_en && acc_we && hit;
        start_miss = acc_en && !hit;
    end

    // Memory array: reset pattern, write-through on hit, store completion on fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= DATA_W'(i) | (DATA_W'(1) << (DATA_W - 4));
        end else if (st_hit) begin
            mem[{acc_row, acc_word}] <= acc_wdata;
        end else if (fin && p_we_q) begin
            mem[{p_row_q, p_word_q}] <= p_wdata_q;
        end
    end

    // Row buffer: one generate lane per word, refilled or written per lane.
    for (genvar w = 0; w < ROW_WORDS; w++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rbuf[w] <= '0;
            end else if (fin) begin
                if (p_we_q && (p_word_q == WORD_AW'(w)))
                    rbuf[w] <= p_wdata_q;
                else
                    rbuf[w] <= mem[{p_row_q, WORD_AW'(w)}];
            end else if (st_hit && (acc_word == WORD_AW'(w))) begin
                rbuf[w] <= acc_wdata;
            end
        end
    end

    // Refill sequencing and tag state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q     <= '0;
            tvalid_q  <= 1'b0;
            busy_q    <= 1'b0;
            cnt_q     <= '0;
            p_we_q    <= 1'b0;
            p_row_q   <= '0;
            p_word_q  <= '0;
            p_wdata_q <= '0;
        end else if (busy_q) begin
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end else begin
                busy_q   <= 1'b0;
                tag_q    <= p_row_q;
                tvalid_q <= 1'b1;
            end
        end else if (start_miss) begin
            busy_q    <= 1'b1;
            cnt_q     <= CNT_W'(MISS_CYCLES - 1);
            p_we_q    <= acc_we;
            p_row_q   <= acc_row;
            p_word_q  <= acc_word;
            p_wdata_q <= acc_wdata;
        end
    end

endmodule

// File: rtl/simd_pe.sv
// SIMD processing element top. Selects one of NCTRL broadcast streams by the
// controller code, masks execution by the activity bit, executes ALU and
// flag instructions, and issues loads and stores to the row buffer. A missing
// load stays pending while independent work continues; hazards raise stall.
// Assumes a controller holds its instruction while stall is high.
module simd_pe
    import simd_pe_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int NCTRL       = 4,
    parameter int ROW_WORDS   = 8,
    parameter int MEM_ROWS    = 16,
    parameter int MISS_CYCLES = 4,
    localparam int CODE_W     = $clog2(NCTRL),
    localparam int WORD_AW    = $clog2(ROW_WORDS),
    localparam int ROW_AW     = $clog2(MEM_ROWS),
    localparam int MEM_AW     = WORD_AW + ROW_AW
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NCTRL-1:0]            ctrl_valid,
    input  logic [NCTRL-1:0][31:0]      ctrl_instr,
    output logic                        stall,
    output logic                        busy,
    output logic [7:0]                  pe_flags,
    output logic                        wb_valid,
    output logic [REG_AW-1:0]           wb_rd,
    output logic [DATA_W-1:0]           wb_data,
    input  logic                        comm_we,
    input  logic [DATA_W-1:0]           comm_wdata,
    output logic [DATA_W-1:0]           comm_rdata
);

    logic              act_q;
    logic [CODE_W-1:0] code_q;
    logic              ld_pend_q;
    logic [REG_AW-1:0] pend_rd_q;

    logic        sel_valid;
    instr_t      ins;
    logic        eff, is_mem, is_ld, writes_rd, uses_rs1, uses_rs2, dep, hazard, go;
    logic [DATA_W-1:0] rd1, rd2, rd3, alu_res;
    logic        alu_zero, alu_neg;
    logic [MEM_AW-1:0] eff_addr;
    logic        hit, fin, rb_busy;
    logic [DATA_W-1:0] hit_rdata, fin_rdata;
    logic        a_we;
    logic [REG_AW-1:0] a_wa;
    logic [DATA_W-1:0] a_wd;

    // Pick the followed controller's stream.
    always_comb begin
        sel_valid = ctrl_valid[code_q];
        ins       = instr_t'(ctrl_instr[code_q]);
    end

    // Decode instruction classes and operand use.
    always_comb begin
        eff       = act_q || (ins.op == OP_ACTALL);
        is_ld     = (ins.op == OP_LD);
        is_mem    = is_ld || (ins.op == OP_ST);
        writes_rd = (ins.op >= OP_ADD) && (ins.op <= OP_LD);
        uses_rs1  = (ins.op >= OP_ADD) && (ins.op <= OP_ACTN);
        uses_rs2  = ((ins.op >= OP_ADD) && (ins.op <= OP_SHR)) ||
                    (ins.op == OP_ACTZ) || (ins.op == OP_ACTN);
    end

    // Hazards against a pending refill; decide acceptance.
    always_comb begin
        dep = ld_pend_q && (
                  (uses_rs1 && (ins.rs1 == pend_rd_q)) ||
                  (uses_rs2 && (ins.rs2 == pend_rd_q)) ||
                  ((writes_rd || ins.op == OP_ST) && (ins.rd == pend_rd_q)));
        hazard = rb_busy && (fin || is_mem || dep);
        go     = sel_valid && eff && !hazard;
        stall  = sel_valid && eff && hazard;
        busy   = rb_busy;
    end

    // Effective word address: low bits of rs1 + sext(imm).
    assign eff_addr = rd1[MEM_AW-1:0] + ins.imm[MEM_AW-1:0];

    simd_pe_regfile #(
        .DATA_W   (DATA_W),
        .NREG     (NREG),
        .COMM_IDX (COMM_REG)
    ) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .a_ra1 (ins.rs1),
        .a_ra2 (ins.rs2),
        .a_ra3 (ins.rd),
        .a_rd1 (rd1),
        .a_rd2 (rd2),
        .a_rd3 (rd3),
        .a_we  (a_we),
        .a_wa  (a_wa),
        .a_wd  (a_wd),
        .b_we  (comm_we),
        .b_wd  (comm_wdata),
        .b_rd  (comm_rdata)
    );

    simd_pe_alu #(.DATA_W(DATA_W)) u_alu (
        .op     (ins.op),
        .a      (rd1),
        .b      (rd2),
        .imm    (ins.imm),
        .result (alu_res),
        .zero   (alu_zero),
        .neg    (alu_neg)
    );

    simd_pe_rowbuf #(
        .DATA_W      (DATA_W),
        .ROW_WORDS   (ROW_WORDS),
        .MEM_ROWS    (MEM_ROWS),
        .MISS_CYCLES (MISS_CYCLES)
    ) u_rb (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (go && is_mem),
        .acc_we    (ins.op == OP_ST),
        .acc_row   (eff_addr[MEM_AW-1:WORD_AW]),
        .acc_word  (eff_addr[WORD_AW-1:0]),
        .acc_wdata (rd3),
        .hit       (hit),
        .hit_rdata (hit_rdata),
        .busy      (rb_busy),
        .fin       (fin),
        .fin_rdata (fin_rdata)
    );

    // Port A write selection: refill completion or an accepted instruction.
    always_comb begin
        if (fin && ld_pend_q) begin
            a_we = 1'b1;
            a_wa = pend_rd_q;
            a_wd = fin_rdata;
        end else begin
            a_we = go && writes_rd && !(is_ld && !hit);
            a_wa = ins.rd;
            a_wd = is_ld ? hit_rdata : alu_res;
        end
    end

    // Flag register: activity bit and controller code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b1;
            code_q <= '0;
        end else if (go) begin
            unique case (ins.op)
                OP_ACTZ:   act_q  <= alu_zero;
                OP_ACTN:   act_q  <= alu_neg;
                OP_ACTALL: act_q  <= 1'b1;
                OP_SETCTL: code_q <= ins.imm[CODE_W-1:0];
                default:   ;
            endcase
        end
    end

    // Pending-load tracking for dependency stalls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_pend_q <= 1'b0;
            pend_rd_q <= '0;
        end else if (fin) begin
            ld_pend_q <= 1'b0;
        end else if (go && is_ld && !hit) begin
            ld_pend_q <= 1'b1;
            pend_rd_q <= ins.rd;
        end
    end

    // Write-back report registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_rd    <= '0;
            wb_data  <= '0;
        end else begin
            wb_valid <= a_we;
            if (a_we) begin
                wb_rd   <= a_wa;
                wb_data <= a_wd;
            end
        end
    end

    assign pe_flags = {{(7 - CODE_W){1'b0}}, code_q, act_q};

endmodule

// File: rtl/simd_pe_chk.sv
// Protocol checker for simd_pe, attached by bind. Observes ports only and
// keeps one counter to measure the busy window.
module simd_pe_chk #(
    parameter int DATA_W      = 32,
    parameter int NCTRL       = 4,
    parameter int MISS_CYCLES = 4,
    localparam int RUN_W      = $clog2(MISS_CYCLES + 2)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCTRL-1:0]  ctrl_valid,
    input logic              stall,
    input logic              busy,
    input logic [7:0]        pe_flags,
    input logic              wb_valid,
    input logic              comm_we,
    input logic [DATA_W-1:0] comm_wdata,
    input logic [DATA_W-1:0] comm_rdata
);

    logic [RUN_W-1:0] run_q;

    // Length of the current busy window, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (busy)
            run_q <= (run_q == {RUN_W{1'b1}}) ? run_q : run_q + 1'b1;
        else
            run_q <= '0;
    end

    assert_miss_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == RUN_W'(MISS_CYCLES)));

    assert_stall_only_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> busy);

    assert_unselected_no_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_valid[pe_flags[2:1]] |-> !stall);

    assert_inactive_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pe_flags[0] && !busy) |=> !wb_valid);

    assert_comm_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (comm_we && !busy && !ctrl_valid[pe_flags[2:1]]) |=> (comm_rdata == $past(comm_wdata)));

endmodule

bind simd_pe simd_pe_chk #(
    .DATA_W      (DATA_W),
    .NCTRL       (NCTRL),
    .MISS_CYCLES (MISS_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_valid (ctrl_valid),
    .stall      (stall),
    .busy       (busy),
    .pe_flags   (pe_flags),
    .wb_valid   (wb_valid),
    .comm_we    (comm_we),
    .comm_wdata (comm_wdata),
    .comm_rdata (comm_rdata)
);

// File: tb/simd_pe_tb.sv
// Bench for simd_pe: directed corner cases followed by seeded random
// instructions, all compared against a bench-side reference model.
module simd_pe_tb;

    localparam int MISS = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [3:0]        ctrl_valid = '0;
    logic [3:0][31:0]  ctrl_instr = '0;
    logic              stall, busy, wb_valid;
    logic [7:0]        pe_flags;
    logic [3:0]        wb_rd;
    logic [31:0]       wb_data;
    logic              comm_we = 1'b0;
    logic [31:0]       comm_wdata = '0;
    logic [31:0]       comm_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] m_reg [16];
    logic [31:0] m_mem [128];
    logic        m_act;
    logic [1:0]  m_code;
    logic [3:0]  m_tag;
    logic        m_tv;

    always #5 clk = ~clk;

    simd_pe #(.MISS_CYCLES(MISS)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_valid(ctrl_valid), .ctrl_instr(ctrl_instr),
        .stall(stall), .busy(busy), .pe_flags(pe_flags), .wb_valid(wb_valid),
        .wb_rd(wb_rd), .wb_data(wb_data), .comm_we(comm_we),
        .comm_wdata(comm_wdata), .comm_rdata(comm_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int op, input int rd, input int rs1,
                                       input int rs2, input logic [15:0] imm);
        return {4'(op), 4'(rd), 4'(rs1), 4'(rs2), imm};
    endfunction

    function automatic logic [31:0] sext(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] alu_ref(input logic [3:0] op, input logic [31:0] a,
                                            input logic [31:0] b, input logic [15:0] imm);
        case (op)
            4'd1: return a + b;
            4'd2: return a - b;
            4'd3: return a & b;
            4'd4: return a | b;
            4'd5: return a ^ b;
            4'd6: return a << b[4:0];
            4'd7: return a >> b[4:0];
            4'd8: return a + sext(imm);
            default: return '0;
        endcase
    endfunction

    // Issue one instruction on the followed controller (garbage on the others),
    // wait for it and any refill, and compare against the model.
    task automatic exec(input logic [31:0] ins);
        logic [3:0] op, rd, rs1, rs2;
        logic [15:0] imm;
        logic [31:0] a, b, exp, addr, sd;
        logic eff, hit;
        int n;
        op = ins[31:28]; rd = ins[27:24]; rs1 = ins[23:20]; rs2 = ins[19:16]; imm = ins[15:0];
        a = m_reg[rs1]; b = m_reg[rs2]; sd = m_reg[rd];
        eff = m_act || (op == 4'd13);
        @(negedge clk);
        for (int c = 0; c < 4; c++) begin
            ctrl_valid[c] = 1'($urandom);
            ctrl_instr[c] = $urandom;
        end
        ctrl_valid[m_code] = 1'b1;
        ctrl_instr[m_code] = ins;
        #1 chk("R8 idle no stall", 32'(stall), 32'd0);
        @(posedge clk);
        @(negedge clk);
        ctrl_valid = '0;
        if (!eff) begin
            chk("R3 masked", 32'(wb_valid), 32'd0);
        end else if (op >= 4'd1 && op <= 4'd8) begin
            exp = alu_ref(op, a, b, imm);
            m_reg[rd] = exp;
            chk("R4 wb_valid", 32'(wb_valid), 32'd1);
            chk("R4 wb_rd", 32'(wb_rd), 32'(rd));
            chk("R4 wb_data", wb_data, exp);
        end else if (op == 4'd9 || op == 4'd10) begin
            addr = a + sext(imm);
            hit = m_tv && (m_tag == addr[6:3]);
            chk(hit ? "R5 hit no busy" : "R6 miss busy", 32'(busy), 32'(!hit));
            n = 0;
            while (busy) begin
                n++;
                @(negedge clk);
            end
            if (!hit) chk("R6 busy cycles", 32'(n), 32'(MISS));
            m_tag = addr[6:3];
            m_tv = 1'b1;
            if (op == 4'd9) begin
                exp = m_mem[addr[6:0]];
                m_reg[rd] = exp;
                chk(hit ? "R5 load wb" : "R6 load wb", 32'(wb_valid), 32'd1);
                chk(hit ? "R5 load data" : "R6 load data", wb_data, exp);
            end else begin
                m_mem[addr[6:0]] = sd;
                chk("R7 store no wb", 32'(wb_valid), 32'd0);
            end
        end else begin
            case (op)
                4'd11: m_act = ((a - b) == 32'd0);
                4'd12: m_act = (a - b) >> 31 != 0;
                4'd13: m_act = 1'b1;
                4'd14: m_code = imm[1:0];
                default: ;
            endcase
            chk("R3 flag op no wb", 32'(wb_valid), 32'd0);
        end
        chk("R2 R3 R10 flags", 32'(pe_flags), {27'd0, m_code, m_act});
        chk("R9 comm read", comm_rdata, m_reg[15]);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int p_rs1;
        logic [15:0] p_imm;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) m_reg[i] = '0;
        for (int i = 0; i < 128; i++) m_mem[i] = 32'h1000_0000 | 32'(i);
        m_act = 1'b1; m_code = 2'd0; m_tag = '0; m_tv = 1'b0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 flags", 32'(pe_flags), 32'h01);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 stall", 32'(stall), 32'd0);
        chk("R1 wb_valid", 32'(wb_valid), 32'd0);
        chk("R1 comm", comm_rdata, 32'd0);

        // R1 / R6: first access misses, then R5 hit in the same row
        exec(mk(9, 1, 0, 0, 16'd8));
        exec(mk(9, 2, 0, 0, 16'd9));
        // R4: directed ALU cases including shift extremes
        exec(mk(8, 3, 0, 0, 16'hFFFB));
        exec(mk(1, 4, 1, 2, 16'd0));
        exec(mk(2, 5, 1, 3, 16'd0));
        exec(mk(8, 6, 0, 0, 16'd31));
        exec(mk(6, 7, 3, 6, 16'd0));
        exec(mk(7, 8, 3, 6, 16'd0));
        exec(mk(5, 9, 1, 3, 16'd0));

        // R2: other controllers valid, followed one idle -> no effect
        @(negedge clk);
        for (int c = 0; c < 4; c++) begin
            ctrl_valid[c] = 1'b1;
            ctrl_instr[c] = mk(8, 10, 0, 0, 16'h0077);
        end
        ctrl_valid[m_code] = 1'b0;
        #1 chk("R2 no stall from others", 32'(stall), 32'd0);
        @(posedge clk); @(negedge clk);
        chk("R2 others ignored", 32'(wb_valid), 32'd0);
        ctrl_valid = '0;
        exec(mk(14, 0, 0, 0, 16'd2));
        exec(mk(8, 10, 0, 0, 16'h0123));
        exec(mk(14, 0, 0, 0, 16'd0));

        // R3: deactivate, masked op, reactivate
        exec(mk(11, 0, 1, 2, 16'd0));
        exec(mk(8, 11, 0, 0, 16'h0055));
        exec(mk(14, 0, 0, 0, 16'd3));
        exec(mk(13, 0, 0, 0, 16'd0));
        exec(mk(12, 0, 3, 0, 16'd0));
        exec(mk(12, 0, 0, 3, 16'd0));
        exec(mk(13, 0, 0, 0, 16'd0));
        exec(mk(14, 0, 0, 0, 16'd0));

        // R8: miss on row 5, independent op proceeds, dependent op waits
        @(negedge clk);
        ctrl_valid[m_code] = 1'b1;
        ctrl_instr[m_code] = mk(9, 3, 0, 0, 16'd40);
        @(posedge clk); @(negedge clk);
        ctrl_instr[m_code] = mk(1, 4, 1, 2, 16'd0);
        #1 chk("R8 independent taken", 32'(stall), 32'd0);
        chk("R6 busy during miss", 32'(busy), 32'd1);
        @(posedge clk); @(negedge clk);
        m_reg[4] = m_reg[1] + m_reg[2];
        chk("R8 independent wb", wb_data, m_reg[4]);
        ctrl_instr[m_code] = mk(1, 5, 3, 1, 16'd0);
        while (busy) begin
            #1 chk("R8 dependent held", 32'(stall), 32'd1);
            @(posedge clk); @(negedge clk);
        end
        m_reg[3] = m_mem[40];
        m_tag = 4'd5; m_tv = 1'b1;
        chk("R6 load at completion", wb_data, m_reg[3]);
        chk("R8 released", 32'(stall), 32'd0);
        @(posedge clk); @(negedge clk);
        ctrl_valid = '0;
        m_reg[5] = m_reg[3] + m_reg[1];
        chk("R8 dependent result", wb_data, m_reg[5]);

        // R8: store during miss and any op in the last busy cycle are held
        @(negedge clk);
        ctrl_valid[m_code] = 1'b1;
        ctrl_instr[m_code] = mk(9, 6, 0, 0, 16'd56);
        @(posedge clk); @(negedge clk);
        ctrl_instr[m_code] = mk(10, 1, 0, 0, 16'd0);
        #1 chk("R8 mem op held", 32'(stall), 32'd1);
        repeat (MISS - 1) begin
            @(posedge clk); @(negedge clk);
        end
        ctrl_instr[m_code] = mk(8, 7, 0, 0, 16'h0042);
        #1 chk("R8 last busy cycle held", 32'(stall), 32'd1);
        @(posedge clk); @(negedge clk);
        m_reg[6] = m_mem[56];
        m_tag = 4'd7;
        chk("R6 fill wb", wb_data, m_reg[6]);
        chk("R8 after fill", 32'(stall), 32'd0);
        @(posedge clk); @(negedge clk);
        ctrl_valid = '0;
        m_reg[7] = 32'h42;
        chk("R8 held op result", wb_data, m_reg[7]);

        // R7: store then load of the same word, miss path and hit path
        exec(mk(10, 4, 0, 0, 16'd41));
        exec(mk(9, 12, 0, 0, 16'd41));
        chk("R7 store visible", m_reg[12], m_reg[4]);
        exec(mk(10, 5, 0, 0, 16'd42));
        exec(mk(9, 13, 0, 0, 16'd42));
        chk("R7 store hit visible", m_reg[13], m_reg[5]);

        // R9: communication write alone, then collision with instruction write
        @(negedge clk);
        comm_we = 1'b1; comm_wdata = 32'hCAFE_0001;
        @(posedge clk); @(negedge clk);
        comm_we = 1'b0;
        m_reg[15] = 32'hCAFE_0001;
        chk("R9 comm write", comm_rdata, m_reg[15]);
        @(negedge clk);
        comm_we = 1'b1; comm_wdata = 32'hDEAD_0002;
        ctrl_valid[m_code] = 1'b1;
        ctrl_instr[m_code] = mk(8, 15, 0, 0, 16'd7);
        @(posedge clk); @(negedge clk);
        comm_we = 1'b0;
        ctrl_valid = '0;
        m_reg[15] = m_reg[0] + 32'd7;
        chk("R9 instruction wins", comm_rdata, m_reg[15]);

        // Random phase
        p_rs1 = 0; p_imm = 16'd0;
        for (int k = 0; k < 400; k++) begin
            int op, rd, rs1, rs2;
            logic [15:0] imm;
            op = int'($urandom % 16);
            if (!m_act && ($urandom % 3 == 0)) op = 13;
            rd = int'($urandom % 16); rs1 = int'($urandom % 16); rs2 = int'($urandom % 16);
            imm = 16'($urandom);
            if ((op == 9 || op == 10) && ($urandom % 2 == 0)) begin
                rs1 = p_rs1;
                imm = p_imm ^ 16'($urandom % 8);
            end
            if (op == 9 || op == 10) begin
                p_rs1 = rs1; p_imm = imm;
            end
            v = mk(op, rd, rs1, rs2, imm);
            exec(v);
        end

        finish_run();
    end

endmodule